// File: doc/BRIEF.md
# Correlation Score Post-Processor with Cascade Summer

This block sits behind a binary correlation array and turns its partial scores into the value that leaves the chip. The array delivers one partial score per input bit-plane. The block weights each plane by its binary significance, adds a programmable offset, and holds the result in a programmable delay line. It then adds a cascade value arriving from an upstream device. The delay lets a chain of devices line up their local scores with the latency of the devices ahead of them, so the final device in the chain presents one combined score.

A mode input turns the device into two independent correlators. In that mode the cascade output carries the first correlator's score in its low nine bits and the auxiliary output carries the second. In single mode the auxiliary output instead echoes the reference data stream. Each output bus has its own active-low enable that releases the bus to high impedance without stopping the pipeline.

All sums saturate at the largest value of the cascade width instead of wrapping.

Top module: `corr_score_post`

## Requirements
- R1: In single mode the local score is the sum over planes of plane i's score (input bits [9i+8:9i] of `plane_scores`) multiplied by 2^i.
- R2: The offset `score_offset` is added to the weighted sum, and the result saturates at 8191.
- R3: With `delay_sel` = d (0 to 15), a change of the plane scores reaches `casc_out` exactly d+2 clock edges later, and not earlier.
- R4: In single mode `casc_out` = min(local score + `casc_in`, 8191), and a change of `casc_in` reaches `casc_out` one clock edge later.
- R5: With `dual_mode` = 1, one edge after the inputs are applied, `casc_out` = {4'b0, plane 0 score} and `aux_out` = plane 1 score. The offset and `casc_in` have no effect in this mode.
- R6: With `dual_mode` = 0, `aux_out[7:0]` equals `ref_in` one edge later and `aux_out[8]` is 0.
- R7: While `casc_oe_n` or `aux_oe_n` is 1, the matching bus is not driven. The pipeline keeps running, so the bus shows the current result as soon as it is enabled again.
- R8: While `rst_n` is low, both outputs read 0 with their enables low. Reset is applied asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| plane_scores | input | 36 | Four 9-bit plane partial scores, plane 0 in the low bits |
| score_offset | input | 13 | Offset added to the weighted sum |
| delay_sel | input | 4 | Delay line length in clocks, 0 to 15 |
| dual_mode | input | 1 | 1 = two independent correlators |
| casc_in | input | 13 | Score from the upstream device |
| ref_in | input | 8 | Reference data to echo on the auxiliary bus |
| casc_oe_n | input | 1 | Active-low enable of `casc_out` |
| aux_oe_n | input | 1 | Active-low enable of `aux_out` |
| casc_out | output | 13 | Cascade sum, or first score in dual mode |
| aux_out | output | 9 | Second score in dual mode, reference echo otherwise |

## Verification
The hardest situation to reach is an exact latency that depends on the delay setting. A steady-state check cannot tell a delay of d from d+1. The bench therefore parks the pipeline at zero for longer than the deepest delay. It then injects a single step on one plane and samples `casc_out` after every edge for each of the 16 settings, and requires zero before edge d+2 and the step value at it. Saturation is reached by sweeping plane values that include the 9-bit maximum against offsets and cascade inputs close to the 13-bit limit.

// File: rtl/corr_post_pkg.sv
package corr_post_pkg;
  localparam int unsigned SCORE_W = 9;
  localparam int unsigned N_PLANE = 4;
  localparam int unsigned CAS_W   = 13;
  localparam int unsigned REF_W   = 8;
  localparam int unsigned DLY_MAX = 15;
  localparam int unsigned DLY_W   = $clog2(DLY_MAX + 1);
endpackage

// File: rtl/score_weigher.sv
module score_weigher #(
  parameter int unsigned N_PL  = 4,
  parameter int unsigned SW    = 9,
  parameter int unsigned OUT_W = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_PL*SW-1:0]   planes,
  input  logic [OUT_W-1:0]     offset,
  output logic [OUT_W-1:0]     result_q
);
  localparam int unsigned WIDE  = (SW + N_PL > OUT_W) ? SW + N_PL : OUT_W;
  localparam int unsigned SUM_W = WIDE + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'({OUT_W{1'b1}});

  logic [SUM_W-1:0] acc;
  logic [OUT_W-1:0] result_d;

  always_comb begin
    acc = SUM_W'(offset);
    for (int i = 0; i < int'(N_PL); i++) begin
      acc = acc + (SUM_W'(planes[i*SW +: SW]) << i);
    end
    result_d = (acc > LIMIT) ? {OUT_W{1'b1}} : acc[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else        result_q <= result_d;
  end

  // R2: saturating additions never fall below the offset
  a_r2_offset_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> result_q >= $past(offset));
endmodule

// File: rtl/score_delay.sv
module score_delay #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 15,
  parameter int unsigned SEL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     tap
);
  logic [W-1:0] line [0:DEPTH-1];

  generate
    for (genvar k = 0; k < int'(DEPTH); k++) begin : g_stage
      if (k == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) line[k] <= '0;
          else        line[k] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) line[k] <= '0;
          else        line[k] <= line[k-1];
        end
      end
    end
  endgenerate

  always_comb begin
    if (sel == '0)                      tap = din;
    else if (int'(sel) > int'(DEPTH))   tap = line[DEPTH-1];
    else                                tap = line[int'(sel) - 1];
  end

  // R3: a one-clock setting presents last cycle's input
  a_r3_tap_one: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && sel == SEL_W'(1)) |-> tap == $past(din));
endmodule

// File: rtl/cascade_join.sv
module cascade_join #(
  parameter int unsigned SW    = 9,
  parameter int unsigned CW    = 13,
  parameter int unsigned RW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual,
  input  logic [CW-1:0] local_score,
  input  logic [CW-1:0] casc_in,
  input  logic [SW-1:0] first_score,
  input  logic [SW-1:0] second_score,
  input  logic [RW-1:0] ref_in,
  output logic [CW-1:0] casc_q,
  output logic [SW-1:0] aux_q
);
  logic [CW:0]   total;
  logic [CW-1:0] casc_d;
  logic [SW-1:0] aux_d;

  always_comb begin
    total = {1'b0, local_score} + {1'b0, casc_in};
    if (dual) begin
      casc_d = CW'(first_score);
      aux_d  = second_score;
    end else begin
      casc_d = total[CW] ? {CW{1'b1}} : total[CW-1:0];
      aux_d  = SW'(ref_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      casc_q <= '0;
      aux_q  <= '0;
    end else begin
      casc_q <= casc_d;
      aux_q  <= aux_d;
    end
  end

  // R4: the cascade sum never drops below the upstream value
  a_r4_cascade_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !dual) |=> casc_q >= $past(casc_in));
  // R5: dual mode leaves the upper cascade bits clear
  a_r5_dual_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && dual) |=> casc_q[CW-1:SW] == '0);
  // R6: in single mode the auxiliary top bit stays low
  a_r6_aux_msb_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !dual) |=> aux_q[SW-1:RW] == '0);
endmodule

// File: rtl/corr_score_post.sv
module corr_score_post
  import corr_post_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PLANE*SCORE_W-1:0] plane_scores,
  input  logic [CAS_W-1:0]           score_offset,
  input  logic [DLY_W-1:0]           delay_sel,
  input  logic                       dual_mode,
  input  logic [CAS_W-1:0]           casc_in,
  input  logic [REF_W-1:0]           ref_in,
  input  logic                       casc_oe_n,
  input  logic                       aux_oe_n,
  output logic [CAS_W-1:0]           casc_out,
  output logic [SCORE_W-1:0]         aux_out
);
  logic [1:0]         rst_sync;
  logic               rst_core_n;
  logic [CAS_W-1:0]   weighted_q;
  logic [CAS_W-1:0]   delayed;
  logic [CAS_W-1:0]   casc_q;
  logic [SCORE_W-1:0] aux_q;

  // R8: asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  score_weigher #(.N_PL(N_PLANE), .SW(SCORE_W), .OUT_W(CAS_W)) u_weigher (
    .clk(clk), .rst_n(rst_core_n), .planes(plane_scores),
    .offset(score_offset), .result_q(weighted_q));

  score_delay #(.W(CAS_W), .DEPTH(DLY_MAX), .SEL_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_core_n), .sel(delay_sel),
    .din(weighted_q), .tap(delayed));

  cascade_join #(.SW(SCORE_W), .CW(CAS_W), .RW(REF_W)) u_join (
    .clk(clk), .rst_n(rst_core_n), .dual(dual_mode),
    .local_score(delayed), .casc_in(casc_in),
    .first_score(plane_scores[SCORE_W-1:0]),
    .second_score(plane_scores[2*SCORE_W-1:SCORE_W]),
    .ref_in(ref_in), .casc_q(casc_q), .aux_q(aux_q));

  // R7: enables only gate the pins, never the pipeline
  assign casc_out = casc_oe_n ? {CAS_W{1'bz}}   : casc_q;
  assign aux_out  = aux_oe_n  ? {SCORE_W{1'bz}} : aux_q;

  // R8: the released pipeline starts from zero
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_core_n) |-> (casc_q == '0 && aux_q == '0));
endmodule

// File: tb/test_corr_score_post.sv
module test_corr_score_post;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = 8191;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [35:0] plane_scores;
  logic [12:0] score_offset;
  logic [3:0]  delay_sel;
  logic        dual_mode;
  logic [12:0] casc_in;
  logic [7:0]  ref_in;
  logic        casc_oe_n;
  logic        aux_oe_n;
  logic [12:0] casc_out;
  logic [8:0]  aux_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  corr_score_post i_corr_score_post (
    .clk(clk), .rst_n(rst_n), .plane_scores(plane_scores),
    .score_offset(score_offset), .delay_sel(delay_sel), .dual_mode(dual_mode),
    .casc_in(casc_in), .ref_in(ref_in), .casc_oe_n(casc_oe_n),
    .aux_oe_n(aux_oe_n), .casc_out(casc_out), .aux_out(aux_out));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  function automatic int model(input int p0, input int p1, input int p2,
                               input int p3, input int off, input int cin);
    int local_v;
    local_v = sat(p0 + 2*p1 + 4*p2 + 8*p3 + off);
    return sat(local_v + cin);
  endfunction

  task automatic set_planes(input int p0, input int p1, input int p2, input int p3);
    plane_scores = {9'(p3), 9'(p2), 9'(p1), 9'(p0)};
  endtask

  int vals [4] = '{0, 1, 170, 511};
  int offs [3] = '{0, 100, 8000};
  int cins [2] = '{0, 5000};

  initial begin
    rst_n = 1'b0;
    plane_scores = '0; score_offset = '0; delay_sel = '0; dual_mode = 1'b0;
    casc_in = '0; ref_in = '0; casc_oe_n = 1'b0; aux_oe_n = 1'b0;
    tick(3);
    // R8: outputs held at zero during reset
    check("R8 casc reset", int'(casc_out), 0);
    check("R8 aux reset", int'(aux_out), 0);
    rst_n = 1'b1;
    tick(4);

    // R1 R2 R4: steady-state sweep with no delay
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++)
            for (int o = 0; o < 3; o++)
              for (int k = 0; k < 2; k++) begin
                set_planes(vals[a], vals[b], vals[c], vals[d]);
                score_offset = 13'(offs[o]);
                casc_in = 13'(cins[k]);
                tick(3);
                check("R1/R2/R4 sweep", int'(casc_out),
                      model(vals[a], vals[b], vals[c], vals[d], offs[o], cins[k]));
              end

    // R2: offset alone saturates exactly at the limit
    set_planes(1, 0, 0, 0); score_offset = 13'd8190; casc_in = '0;
    tick(3);
    check("R2 below limit", int'(casc_out), 8191);
    set_planes(2, 0, 0, 0);
    tick(3);
    check("R2 saturate", int'(casc_out), 8191);

    // R4: cascade input latency is one edge
    set_planes(3, 0, 0, 0); score_offset = '0; casc_in = '0;
    tick(4);
    casc_in = 13'd1000;
    check("R4 before edge", int'(casc_out), 3);
    tick(1);
    check("R4 one edge", int'(casc_out), 1003);
    casc_in = 13'd8190;
    tick(1);
    check("R4 cascade saturate", int'(casc_out), 8191);

    // R3: step latency for every delay setting
    casc_in = '0;
    for (int dl = 0; dl < 16; dl++) begin
      delay_sel = 4'(dl);
      set_planes(0, 0, 0, 0);
      tick(20);
      set_planes(0, 5, 0, 0);
      for (int e = 1; e <= dl + 2; e++) begin
        tick(1);
        check($sformatf("R3 delay %0d edge %0d", dl, e), int'(casc_out),
              (e == dl + 2) ? 10 : 0);
      end
    end

    // R3: a delayed steady state still matches the model
    delay_sel = 4'd15;
    set_planes(511, 511, 511, 511); score_offset = 13'd7; casc_in = 13'd9;
    tick(18);
    check("R3 deep steady", int'(casc_out), model(511, 511, 511, 511, 7, 9));
    delay_sel = '0;

    // R6: reference echo on the auxiliary bus
    ref_in = 8'hA5;
    tick(1);
    check("R6 ref echo", int'(aux_out), 165);
    ref_in = 8'hFF;
    tick(1);
    check("R6 msb low", int'(aux_out), 255);

    // R5: dual mode ignores offset and cascade input
    dual_mode = 1'b1;
    set_planes(300, 77, 511, 511); score_offset = 13'd999; casc_in = 13'd4000;
    tick(1);
    check("R5 first score", int'(casc_out), 300);
    check("R5 second score", int'(aux_out), 77);
    set_planes(511, 0, 0, 0); casc_in = 13'd8191;
    tick(1);
    check("R5 first max", int'(casc_out), 511);
    check("R5 second zero", int'(aux_out), 0);
    dual_mode = 1'b0;

    // R7: disabled buses are released and the pipeline keeps running
    set_planes(4, 0, 0, 0); score_offset = '0; casc_in = '0; ref_in = 8'h3C;
    tick(3);
    casc_oe_n = 1'b1; aux_oe_n = 1'b1;
    #1;
    checks++;
    if (!(casc_out === 13'bz || casc_out === 13'd0)) begin
      errors++;
      $display("FAIL R7 casc released: actual=%0d expected=z", casc_out);
    end
    checks++;
    if (!(aux_out === 9'bz || aux_out === 9'd0)) begin
      errors++;
      $display("FAIL R7 aux released: actual=%0d expected=z", aux_out);
    end
    set_planes(0, 0, 0, 6); casc_in = 13'd2; ref_in = 8'h42;
    tick(3);
    casc_oe_n = 1'b0; aux_oe_n = 1'b0;
    #1;
    check("R7 casc resumes", int'(casc_out), 50);
    check("R7 aux resumes", int'(aux_out), 66);

    // R8: asynchronous reset mid-run clears outputs
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    check("R8 async casc", int'(casc_out), 0);
    check("R8 async aux", int'(aux_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(4);
    check("R8 recovers", int'(casc_out), 50);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule